// File: doc/BRIEF.md
# Byte Block Move Engine

This sequencer copies a run of bytes from one place in a 16-bit byte-addressed memory to another. The caller presents a byte count and two pointers, one for where to read and one for where to write, and pulses a start input. For every byte the engine reads at the read pointer, writes that byte at the write pointer, then advances both pointers by one and lowers the count by one. It stops when the count reaches zero.

A count of zero at start moves nothing: the engine finishes at once. When the move finishes, a one-cycle done pulse marks the moment at which the final count and the two advanced pointers are valid for the caller to store back. While a move is running, further start requests are not acted on. The memory port is byte-wide and has a fixed read latency of one cycle.

Top module: `bbm_engine`

## Requirements
- R1: After reset the engine is idle: `done_o`, `mem_rd_o` and `mem_wr_o` are all 0, and no memory request is issued while idle.
- R2: A start with `cnt_i` equal to 0 raises `done_o` in the cycle after the start is sampled, with no memory read or write at all, and `cnt_o`, `src_o`, `dst_o` then equal the values given at start.
- R3: Byte k of a move (k counted from 0) is read with `mem_rd_o`=1 and `mem_addr_o` = source+k, and in the very next cycle is written with `mem_wr_o`=1, `mem_addr_o` = destination+k and `mem_wdata_o` equal to the byte the memory returned. Read and write are never requested together.
- R4: Each byte takes exactly three cycles. If the start is sampled at clock edge E, byte k is read in cycle 3k+1 after E and written in cycle 3k+2 after E. After each byte the count drops by one and both pointers rise by one.
- R5: Pointer increments wrap modulo 2^16, so 16'hFFFF is followed by 16'h0000.
- R6: For a nonzero count N, `done_o` is high for exactly one cycle, in cycle 3N+1 after E; in that cycle `cnt_o` is 0, `src_o` is source+N and `dst_o` is destination+N (mod 2^16).
- R7: A start raised while a move is in progress is ignored: the running move's addresses, data, timing and final values are unchanged, and no further move follows.
- R8: The read data is expected on `mem_rdata_i` in the cycle after the read request; the full 8-bit count range (up to 255 bytes) is moved in one operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| cnt_i | input | 8 | Number of bytes to move |
| src_i | input | 16 | First read address |
| dst_i | input | 16 | First write address |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the read |
| done_o | output | 1 | One-cycle completion pulse |
| cnt_o | output | 8 | Current count, 0 at completion |
| src_o | output | 16 | Current read pointer, advanced at completion |
| dst_o | output | 16 | Current write pointer, advanced at completion |

## Verification
Every expected event carries the cycle in which it is due, counted from the edge that samples start: the read of byte k one cycle plus three per earlier byte after it, its write one cycle later, and the done pulse 3N+1 cycles after it, or one cycle for a zero count. The driver queues these events with their due cycles before raising start, and the monitor samples on the falling edge, pops the next event whenever a read, write or done appears, and compares kind, cycle, address, data and final register values. Any memory activity with nothing queued, or a done high for a second cycle, counts as a miscompare, which covers the zero-count and busy-start cases.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WRITE  = 3'd2,
        ST_UPDATE = 3'd3,
        ST_DONE   = 3'd4
    } bbm_state_e;

    typedef struct packed {
        bbm_state_e state;
    } bbm_seq_t;

endpackage

// File: rtl/bbm_seq.sv
module bbm_seq
    import bbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cnt_zero_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic rd_o,
    output logic wr_o,
    output logic sel_dst_o,
    output logic done_o,
    output logic busy_o
);

    bbm_seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        load_o = 1'b0;
        step_o = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    load_o      = 1'b1;
                    seq_d.state = cnt_zero_i ? ST_DONE : ST_READ;
                end
            end
            ST_READ:   seq_d.state = ST_WRITE;
            ST_WRITE:  seq_d.state = ST_UPDATE;
            ST_UPDATE: begin
                step_o      = 1'b1;
                seq_d.state = last_i ? ST_DONE : ST_READ;
            end
            ST_DONE:   seq_d.state = ST_IDLE;
            default:   seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_o      = (seq_q.state == ST_READ);
    assign wr_o      = (seq_q.state == ST_WRITE);
    assign sel_dst_o = (seq_q.state == ST_WRITE);
    assign done_o    = (seq_q.state == ST_DONE);
    assign busy_o    = (seq_q.state != ST_IDLE);

endmodule

// File: rtl/bbm_regs.sv
module bbm_regs #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic              last_o
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (load_i) begin
            regs_d.cnt = cnt_i;
            regs_d.src = src_i;
            regs_d.dst = dst_i;
        end else if (step_i) begin
            regs_d.cnt = regs_q.cnt - CNT_ONE;
            regs_d.src = regs_q.src + ADDR_ONE;
            regs_d.dst = regs_q.dst + ADDR_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cnt_o  = regs_q.cnt;
    assign src_o  = regs_q.src;
    assign dst_o  = regs_q.dst;
    assign last_o = (regs_q.cnt == CNT_ONE);

endmodule

// File: rtl/bbm_engine.sv
module bbm_engine #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o
);

    logic load;
    logic step;
    logic last;
    logic sel_dst;
    logic busy;
    logic cnt_zero;

    assign cnt_zero = (cnt_i == '0);

    bbm_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cnt_zero_i (cnt_zero),
        .last_i     (last),
        .load_o     (load),
        .step_o     (step),
        .rd_o       (mem_rd_o),
        .wr_o       (mem_wr_o),
        .sel_dst_o  (sel_dst),
        .done_o     (done_o),
        .busy_o     (busy)
    );

    bbm_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .cnt_i  (cnt_i),
        .src_i  (src_i),
        .dst_i  (dst_i),
        .cnt_o  (cnt_o),
        .src_o  (src_o),
        .dst_o  (dst_o),
        .last_o (last)
    );

    assign mem_addr_o  = sel_dst ? dst_o : src_o;
    assign mem_wdata_o = mem_rdata_i;

endmodule

// File: rtl/bbm_engine_chk.sv
module bbm_engine_chk #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  cnt_o,
    input logic [ADDR_W-1:0] src_o,
    input logic [ADDR_W-1:0] dst_o
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_o && !mem_wr_o)); // R1

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)); // R3

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> mem_wr_o); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && (cnt_o != $past(cnt_o)))
            |-> (cnt_o == CNT_W'($past(cnt_o) - 1'b1))); // R4

    AST_SRC_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && (src_o != $past(src_o)))
            |-> (src_o == ADDR_W'($past(src_o) + 1'b1))); // R5

    AST_DST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && (dst_o != $past(dst_o)))
            |-> (dst_o == ADDR_W'($past(dst_o) + 1'b1))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cnt_o == '0)); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_o && start_i)
            |=> ((cnt_o == $past(cnt_o)) || (cnt_o == CNT_W'($past(cnt_o) - 1'b1)))); // R7

endmodule

bind bbm_engine bbm_engine_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy     (busy),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .done_o   (done_o),
    .cnt_o    (cnt_o),
    .src_o    (src_o),
    .dst_o    (dst_o)
);

// File: tb/bbm_engine_tb_top.sv
module bbm_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  cnt_i = '0;
    logic [15:0] src_i = '0;
    logic [15:0] dst_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o;
    logic        mem_wr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        done_o;
    logic [7:0]  cnt_o;
    logic [15:0] src_o;
    logic [15:0] dst_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 1'b0;
    bit prev_done = 1'b0;

    typedef struct {
        int          kind;   // 0 read, 1 write, 2 done
        int          due;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  cnt;
        logic [15:0] src;
        logic [15:0] dst;
        string       req;
    } item_t;

    item_t exp_q[$];
    logic [7:0] mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    bbm_engine dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cnt_i       (cnt_i),
        .src_i       (src_i),
        .dst_i       (dst_i),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .done_o      (done_o),
        .cnt_o       (cnt_o),
        .src_o       (src_o),
        .dst_o       (dst_o)
    );

    function automatic logic [7:0] peek(logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // memory model: one-cycle read latency (R8)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_o) mem_rdata_i <= peek(mem_addr_o);
        if (mem_wr_o) mem[int'(mem_addr_o)] = mem_wdata_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_item(input int kind);
        item_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected activity kind", kind, -1);
            return;
        end
        e = exp_q.pop_front();
        check(e.kind == kind, e.req, "event kind", kind, e.kind);
        check(e.due == cyc, "R4", "event cycle", cyc, e.due);
        if (kind == 0) begin
            check(mem_addr_o == e.addr, "R3", "read address", mem_addr_o, e.addr);
        end else if (kind == 1) begin
            check(mem_addr_o == e.addr, "R3", "write address", mem_addr_o, e.addr);
            check(mem_wdata_o == e.data, "R3", "write data", mem_wdata_o, e.data);
        end else begin
            check(cnt_o == e.cnt, e.req, "final count", cnt_o, e.cnt);
            check(src_o == e.src, "R5", "final source", src_o, e.src);
            check(dst_o == e.dst, "R5", "final destination", dst_o, e.dst);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_rd_o) compare_item(0);
            if (mem_wr_o) compare_item(1);
            if (done_o)   compare_item(2);
            if (prev_done) check(!done_o, "R6", "done held a second cycle", done_o, 0);
            prev_done = done_o;
        end
    end

    // driver: queue expected events, then start
    task automatic run_move(input logic [7:0] n, input logic [15:0] s,
                            input logic [15:0] d, input bit poke, input string req);
        item_t e;
        int    e0;
        @(negedge clk);
        e0 = cyc + 1;
        for (int k = 0; k < int'(n); k++) begin
            e = '{kind: 0, due: e0 + 3*k, addr: s + 16'(k), data: 8'h0,
                  cnt: 8'h0, src: 16'h0, dst: 16'h0, req: "R3"};
            exp_q.push_back(e);
            e = '{kind: 1, due: e0 + 3*k + 1, addr: d + 16'(k), data: peek(s + 16'(k)),
                  cnt: 8'h0, src: 16'h0, dst: 16'h0, req: "R3"};
            exp_q.push_back(e);
        end
        e = '{kind: 2, due: (n == 0) ? e0 : e0 + 3*int'(n), addr: 16'h0, data: 8'h0,
              cnt: 8'h0, src: s + 16'(n), dst: d + 16'(n), req: (n == 0) ? "R2" : "R6"};
        exp_q.push_back(e);
        start_i = 1'b1;
        cnt_i   = n;
        src_i   = s;
        dst_i   = d;
        @(negedge clk);
        start_i = 1'b0;
        cnt_i   = 8'h0;
        if (poke) begin
            repeat (4) @(negedge clk);
            start_i = 1'b1;     // R7: start while busy
            cnt_i   = 8'd3;
            src_i   = 16'h9000;
            dst_i   = 16'h9100;
            @(negedge clk);
            start_i = 1'b0;
            cnt_i   = 8'h0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, req, "events left after move", exp_q.size(), 0);
    endtask

    task automatic finish_run;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        check(mem_rd_o == 1'b0, "R1", "read after reset", mem_rd_o, 0);
        check(mem_wr_o == 1'b0, "R1", "write after reset", mem_wr_o, 0);
        check(cnt_o == 8'h0, "R1", "count after reset", cnt_o, 0);
        run_move(8'd0,   16'h1000, 16'h2000, 1'b0, "R2");
        run_move(8'd1,   16'h1100, 16'h2100, 1'b0, "R3");
        run_move(8'd5,   16'h1200, 16'h2200, 1'b0, "R4");
        run_move(8'd4,   16'hFFFE, 16'h7FFD, 1'b0, "R5");
        run_move(8'd6,   16'h1300, 16'h2300, 1'b1, "R7");
        run_move(8'd255, 16'h3000, 16'h4000, 1'b0, "R8");
        run_move(8'd2,   16'h4000, 16'h5000, 1'b0, "R6");
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
            finish_run();
        end
    end

endmodule